// File: doc/BRIEF.md
# Priority Interrupt Evaluator

The evaluator decides whether a pending interrupt should preempt the code that is running. It holds a software interrupt request register and a current priority level register, both loaded over a shared write-data bus. It also watches an external interrupt status vector. A return-from-handler strobe arms an evaluation. On the evaluation edge the block scans both request sources, finds the highest pending level and builds a summary vector of every pending bit.

When the winning level is above the current priority level, the block pulses a trap request for one cycle. In the same cycle it loads the summary vector into the summary register and the winning level into the interrupt-ID register. When no trap is taken, both registers keep their previous contents. Software requests sit in bits 4 to 18 and give levels 1 to 15. External requests sit in bits 20 to 23 and give levels equal to their bit index. External requests therefore always outrank software requests.

Top module: `prio_irq_eval`

## Requirements
- R1: The software request register keeps only bits 4 to 18 of a written value (mask 0x0007FFF0). It resets to 0 and is visible on sw_req_o one cycle after a write.
- R2: The current priority level register keeps only the low 5 bits of wdata_i. It resets to 0 and is visible on cur_lvl_o one cycle after a write.
- R3: A pending software bit i (4 to 18) gives level i-3. The highest pending software bit sets the software level.
- R4: A set external bit i (20 to 23) gives level i and beats any software level. External bits outside 20 to 23 are ignored.
- R5: The summary vector has a 1 at the position of every pending software bit (4 to 18) and every set external bit (20 to 23), and a 0 everywhere else.
- R6: A trap is taken only when the winning level is nonzero and strictly greater than the current priority level. A scan that finds no pending bit gives level 0 and no trap.
- R7: When a trap is taken, summary_o and int_id_o load the summary vector and the winning level. When no trap is taken, both hold their previous values.
- R8: An evaluation runs only while the check flag is set. ret_i sets the flag on a clock edge. The next edge evaluates and clears the flag, unless ret_i is asserted again. trap_o is high for the one cycle after that evaluation edge.
- R9: After reset, trap_o, int_id_o and summary_o are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wdata_i | input | 32 | Write data for the request and level registers |
| sw_we_i | input | 1 | Write strobe for the software request register |
| lvl_we_i | input | 1 | Write strobe for the current priority level register |
| ext_irq_i | input | 32 | External interrupt status vector |
| ret_i | input | 1 | Handler return; arms an evaluation |
| trap_o | output | 1 | One-cycle interrupt trap request |
| int_id_o | output | 5 | Level of the last trap taken |
| summary_o | output | 32 | Pending-bit summary of the last trap taken |
| sw_req_o | output | 32 | Current software request register |
| cur_lvl_o | output | 5 | Current priority level register |

## Verification
Register writes appear on sw_req_o and cur_lvl_o one cycle after the strobe. A ret_i strobe sets the check flag on the first edge, and the second edge evaluates. That edge updates trap_o, int_id_o and summary_o together. All inputs are driven on falling edges. The results are sampled on the falling edge two cycles after ret_i is raised, and trap_o is checked again one cycle later to confirm the pulse has dropped. In the hold and no-evaluation cases, the outputs are read back at the same point to show they did not move.

// File: rtl/pie_pkg.sv
package pie_pkg;
  localparam int VEC_W = 32;
  localparam int LVL_W = 5;
  localparam int SW_LO = 4;
  localparam int SW_HI = 18;
  localparam int EX_LO = 20;
  localparam int EX_HI = 23;
endpackage

// File: rtl/pie_regs.sv
module pie_regs #(
  parameter int VEC_W = pie_pkg::VEC_W,
  parameter int LVL_W = pie_pkg::LVL_W,
  parameter int SW_LO = pie_pkg::SW_LO,
  parameter int SW_HI = pie_pkg::SW_HI
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VEC_W-1:0] wdata_i,
  input  logic             sw_we_i,
  input  logic             lvl_we_i,
  output logic [VEC_W-1:0] sw_req_o,
  output logic [LVL_W-1:0] cur_lvl_o
);
  logic [VEC_W-1:0] sw_mask;

  for (genvar b = 0; b < VEC_W; b++) begin : g_mask
    assign sw_mask[b] = (b >= SW_LO) && (b <= SW_HI);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_req_o  <= '0;
      cur_lvl_o <= '0;
    end else begin
      if (sw_we_i)  sw_req_o  <= wdata_i & sw_mask;
      if (lvl_we_i) cur_lvl_o <= wdata_i[LVL_W-1:0];
    end
  end

  // R1
  sw_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_we_i |=> sw_req_o == ($past(wdata_i) & sw_mask));

  // R2
  lvl_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_we_i |=> cur_lvl_o == $past(wdata_i[LVL_W-1:0]));
endmodule

// File: rtl/pie_scan.sv
module pie_scan #(
  parameter int VEC_W = pie_pkg::VEC_W,
  parameter int LVL_W = pie_pkg::LVL_W,
  parameter int SW_LO = pie_pkg::SW_LO,
  parameter int SW_HI = pie_pkg::SW_HI,
  parameter int EX_LO = pie_pkg::EX_LO,
  parameter int EX_HI = pie_pkg::EX_HI
) (
  input  logic [VEC_W-1:0] sw_req_i,
  input  logic [VEC_W-1:0] ext_irq_i,
  output logic [LVL_W-1:0] level_o,
  output logic [VEC_W-1:0] pend_o
);
  // ascending scan: the last hit is the highest; external range scanned last
  always_comb begin
    level_o = '0;
    pend_o  = '0;
    for (int i = SW_LO; i <= SW_HI; i++) begin
      if (sw_req_i[i]) begin
        level_o   = LVL_W'(i - SW_LO + 1);
        pend_o[i] = 1'b1;
      end
    end
    for (int i = EX_LO; i <= EX_HI; i++) begin
      if (ext_irq_i[i]) begin
        level_o   = LVL_W'(i);
        pend_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pie_eval.sv
module pie_eval #(
  parameter int VEC_W = pie_pkg::VEC_W,
  parameter int LVL_W = pie_pkg::LVL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ret_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic [VEC_W-1:0] pend_i,
  input  logic [LVL_W-1:0] cur_lvl_i,
  output logic             trap_o,
  output logic [LVL_W-1:0] int_id_o,
  output logic [VEC_W-1:0] summary_o
);
  logic chk_q;
  logic take;

  assign take = chk_q && (level_i != '0) && (level_i > cur_lvl_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_q     <= 1'b0;
      trap_o    <= 1'b0;
      int_id_o  <= '0;
      summary_o <= '0;
    end else begin
      chk_q  <= ret_i;  // evaluation clears, return re-arms
      trap_o <= take;
      if (take) begin
        int_id_o  <= level_i;
        summary_o <= pend_i;
      end
    end
  end

  // R6
  trap_above_lvl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (int_id_o > $past(cur_lvl_i)));

  // R8
  trap_needs_chk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> $past(chk_q));

  // R7
  summary_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_o |-> ($stable(summary_o) && $stable(int_id_o)));
endmodule

// File: rtl/prio_irq_eval.sv
module prio_irq_eval #(
  parameter int VEC_W = pie_pkg::VEC_W,
  parameter int LVL_W = pie_pkg::LVL_W,
  parameter int SW_LO = pie_pkg::SW_LO,
  parameter int SW_HI = pie_pkg::SW_HI,
  parameter int EX_LO = pie_pkg::EX_LO,
  parameter int EX_HI = pie_pkg::EX_HI
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VEC_W-1:0] wdata_i,
  input  logic             sw_we_i,
  input  logic             lvl_we_i,
  input  logic [VEC_W-1:0] ext_irq_i,
  input  logic             ret_i,
  output logic             trap_o,
  output logic [LVL_W-1:0] int_id_o,
  output logic [VEC_W-1:0] summary_o,
  output logic [VEC_W-1:0] sw_req_o,
  output logic [LVL_W-1:0] cur_lvl_o
);
  logic [LVL_W-1:0] level;
  logic [VEC_W-1:0] pend;

  pie_regs #(.VEC_W(VEC_W), .LVL_W(LVL_W), .SW_LO(SW_LO), .SW_HI(SW_HI)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wdata_i(wdata_i), .sw_we_i(sw_we_i),
    .lvl_we_i(lvl_we_i), .sw_req_o(sw_req_o), .cur_lvl_o(cur_lvl_o)
  );

  pie_scan #(.VEC_W(VEC_W), .LVL_W(LVL_W), .SW_LO(SW_LO), .SW_HI(SW_HI),
             .EX_LO(EX_LO), .EX_HI(EX_HI)) u_scan (
    .sw_req_i(sw_req_o), .ext_irq_i(ext_irq_i), .level_o(level), .pend_o(pend)
  );

  pie_eval #(.VEC_W(VEC_W), .LVL_W(LVL_W)) u_eval (
    .clk_i(clk_i), .rst_ni(rst_ni), .ret_i(ret_i), .level_i(level), .pend_i(pend),
    .cur_lvl_i(cur_lvl_o), .trap_o(trap_o), .int_id_o(int_id_o), .summary_o(summary_o)
  );
endmodule

// File: tb/prio_irq_eval_test.sv
module prio_irq_eval_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] wdata = '0;
  logic        sw_we = 1'b0;
  logic        lvl_we = 1'b0;
  logic [31:0] ext = '0;
  logic        ret = 1'b0;
  logic        trap;
  logic [4:0]  id;
  logic [31:0] summ;
  logic [31:0] swq;
  logic [4:0]  lvlq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  prio_irq_eval uut (
    .clk_i(clk), .rst_ni(rst_n), .wdata_i(wdata), .sw_we_i(sw_we), .lvl_we_i(lvl_we),
    .ext_irq_i(ext), .ret_i(ret), .trap_o(trap), .int_id_o(id), .summary_o(summ),
    .sw_req_o(swq), .cur_lvl_o(lvlq)
  );

  typedef struct packed {
    logic [31:0] sw;
    logic [31:0] ex;
    logic [7:0]  lvl;
    logic        trap;
    logic [4:0]  id;
    logic [31:0] sum;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0010, 32'h0000_0000, 8'h00, 1'b1, 5'd1,  32'h0000_0010},
    '{32'h0004_0000, 32'h0000_0000, 8'h0E, 1'b1, 5'd15, 32'h0004_0000},
    '{32'h0004_0000, 32'h0000_0000, 8'h0F, 1'b0, 5'd15, 32'h0004_0000},
    '{32'h0000_000F, 32'h0000_0000, 8'h00, 1'b0, 5'd15, 32'h0004_0000},
    '{32'h0000_0110, 32'h0010_0000, 8'h07, 1'b1, 5'd20, 32'h0010_0110},
    '{32'h0008_0020, 32'h0088_0001, 8'h16, 1'b1, 5'd23, 32'h0080_0020},
    '{32'h0000_7000, 32'h0000_0000, 8'h2A, 1'b1, 5'd11, 32'h0000_7000},
    '{32'h0000_0000, 32'h00F0_0000, 8'hFF, 1'b0, 5'd11, 32'h0000_7000}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic write_regs(input logic [31:0] sw, input logic [31:0] lv);
    @(negedge clk); wdata = sw; sw_we = 1'b1;
    @(negedge clk); sw_we = 1'b0; wdata = lv; lvl_we = 1'b1;
    @(negedge clk); lvl_we = 1'b0;
  endtask

  task automatic pulse_ret;
    ret = 1'b1;
    @(negedge clk); ret = 1'b0;
    @(negedge clk);  // flag set, then evaluated; results visible here
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check(trap == 1'b0, "R9 trap", 32'(trap), 0);
    check(id == 5'd0, "R9 id", 32'(id), 0);
    check(summ == 32'd0, "R9 summary", summ, 0);
    check(swq == 32'd0 && lvlq == 5'd0, "R9 regs", swq, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 and R2 write masking
    write_regs(32'hFFFF_FFFF, 32'h0000_00FF);
    check(swq == 32'h0007_FFF0, "R1 sw mask", swq, 32'h0007_FFF0);
    check(lvlq == 5'h1F, "R2 lvl mask", 32'(lvlq), 32'h1F);

    // vector table: R3 R4 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      write_regs(VECS[v].sw, 32'(VECS[v].lvl));
      ext = VECS[v].ex;
      pulse_ret();
      check(trap == VECS[v].trap, $sformatf("R6 vec%0d trap", v), 32'(trap), 32'(VECS[v].trap));
      check(id == VECS[v].id, $sformatf("R3/R4 vec%0d id", v), 32'(id), 32'(VECS[v].id));
      check(summ == VECS[v].sum, $sformatf("R5/R7 vec%0d summary", v), summ, VECS[v].sum);
      @(negedge clk);
      check(trap == 1'b0, $sformatf("R8 vec%0d pulse", v), 32'(trap), 0);
      ext = '0;
    end

    // R8: no evaluation without a return strobe
    write_regs(32'h0000_0010, 32'h0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(trap == 1'b0 && id == 5'd11, "R8 idle", 32'(id), 32'd11);
    end
    pulse_ret();
    check(trap == 1'b1 && id == 5'd1, "R8 rearm", 32'(id), 32'd1);
    check(summ == 32'h10, "R5 rearm summary", summ, 32'h10);

    // R4: external bit 19 and bit 24 are outside the external range
    ext = 32'h0108_0000;
    write_regs(32'h0000_0000, 32'h0);
    pulse_ret();
    check(trap == 1'b0 && id == 5'd1, "R4 out of range ext", 32'(id), 32'd1);
    ext = '0;

    done = 1'b1;
    finish_run();
  end
endmodule